// File: doc/BRIEF.md
# Banked Memory Paging Register

This block holds the paging control byte for a processor with a 64K address space and a Z80-style I/O write strobe. The space is cut into four 16K slots.

- The lowest slot shows one of two ROMs.
- The second slot is wired to RAM bank 5.
- The third slot is wired to RAM bank 2.
- The top slot shows any one of eight 16K RAM banks, as picked by software.

A separate field picks which of two RAM banks the video logic scans out.

The register is write-only. It answers any I/O write whose address has bits 1 and 15 both low. A lock bit in the written byte freezes the whole register until reset, so that software cannot change paging again after it has given up control.

For the address currently on the memory bus, the block also reports which device and bank it reaches. It flags the access as contended when it lands in an odd-numbered RAM bank.

Top module: `bank_pager`

## Requirements
- R1: After reset, rom_sel is 0, slot3_bank is 0, video_bank is 5, and the register is unlocked, so the next decoded write is taken.
- R2: A write is decoded only when io_wr is 1, io_addr[1] is 0 and io_addr[15] is 0. Other address bits are ignored. A write failing the decode leaves every output unchanged.
- R3: Bits 2:0 of an accepted byte give the RAM bank shown at 0xC000-0xFFFF (slot3_bank). The new value is visible from the clock edge that samples the write.
- R4: Bit 3 of an accepted byte picks the video bank: 0 gives bank 5 and 1 gives bank 7. It never changes slot1_bank.
- R5: Bit 4 of an accepted byte drives rom_sel, which picks ROM 0 or ROM 1 for 0x0000-0x3FFF.
- R6: An accepted byte with bit 5 set takes effect in full and then locks the register. While locked, every write is ignored.
- R7: slot1_bank (0x4000-0x7FFF) is always 5, and slot2_bank (0x8000-0xBFFF) is always 2.
- R8: For mem_addr in 0x0000-0x3FFF, mem_is_rom is 1 and mem_contended is 0. Otherwise mem_bank is the bank of the slot picked by mem_addr[15:14], and mem_contended is 1 exactly when that bank is odd (1, 3, 5 or 7).
- R9: Bits 7:6 of a written byte have no effect on any output.
- R10: Reset releases the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data |
| mem_addr | input | 16 | Current memory address |
| rom_sel | output | 1 | ROM shown in the lowest slot |
| slot1_bank | output | 3 | RAM bank at 0x4000 |
| slot2_bank | output | 3 | RAM bank at 0x8000 |
| slot3_bank | output | 3 | RAM bank at 0xC000 |
| video_bank | output | 3 | RAM bank the display scans |
| mem_is_rom | output | 1 | mem_addr falls in the ROM slot |
| mem_bank | output | 3 | RAM bank reached by mem_addr (0 when ROM) |
| mem_contended | output | 1 | mem_addr reaches an odd RAM bank |

## Verification
A wrong stored byte shows on slot3_bank, rom_sel or video_bank at the first negedge after the write edge. It also shows at once on mem_bank and mem_contended when mem_addr is in the top slot.

A stuck or missing lock shows only on the next write: the outputs either change when they should hold, or hold when they should change. For this reason the bench always follows a locking write with a probe write.

A decode fault shows as a change, or a missing change, one cycle after a write to an address that differs only in bit 1 or bit 15.

// File: rtl/bank_pager_pkg.sv
package bank_pager_pkg;
  localparam int BANK_W   = 3;
  localparam int NSLOT    = 4;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam logic [BANK_W-1:0] SLOT1_FIXED = 3'd5;
  localparam logic [BANK_W-1:0] SLOT2_FIXED = 3'd2;
  localparam logic [BANK_W-1:0] VID_NORMAL  = 3'd5;
  localparam logic [BANK_W-1:0] VID_SHADOW  = 3'd7;

  typedef struct packed {
    logic              lock;
    logic              rom;
    logic              shadow;
    logic [BANK_W-1:0] bank;
  } pg_cfg_t;

  // Unpack a written byte into the control fields.
  function automatic pg_cfg_t cfg_from_byte(input logic [7:0] d);
    pg_cfg_t c;
    c.bank   = d[BANK_W-1:0];
    c.shadow = d[3];
    c.rom    = d[4];
    c.lock   = d[5];
    return c;
  endfunction

  // RAM bank in a given slot (slot 0 is the ROM; 0 is returned there).
  function automatic logic [BANK_W-1:0] slot_bank(input logic [SLOT_W-1:0] s,
                                                  input pg_cfg_t c);
    case (s)
      2'd1:    return SLOT1_FIXED;
      2'd2:    return SLOT2_FIXED;
      2'd3:    return c.bank;
      default: return '0;
    endcase
  endfunction

  // Odd-numbered banks share the bus with the video fetch.
  function automatic logic bank_contended(input logic [BANK_W-1:0] b);
    return b[0];
  endfunction
endpackage

// File: rtl/bank_pager_decode.sv
module bank_pager_decode #(
  parameter int ADDR_W = 16,
  parameter int ZERO_A = 1,
  parameter int ZERO_B = 15
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit
);
  always_comb hit = io_wr && !io_addr[ZERO_A] && !io_addr[ZERO_B];
endmodule

// File: rtl/bank_pager_reg.sv
module bank_pager_reg
  import bank_pager_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [7:0] data,
  output pg_cfg_t    cfg,
  output logic       take
);
  always_comb take = hit && !cfg.lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= '0;
    else if (take) cfg <= cfg_from_byte(data);
  end
endmodule

// File: rtl/bank_pager_map.sv
module bank_pager_map
  import bank_pager_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  pg_cfg_t           cfg,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] slot_banks [NSLOT],
  output logic [BANK_W-1:0] video_bank,
  output logic              mem_is_rom,
  output logic [BANK_W-1:0] mem_bank,
  output logic              mem_contended
);
  logic [SLOT_W-1:0] cur_slot;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_comb slot_banks[s] = slot_bank(SLOT_W'(s), cfg);
  end

  always_comb begin
    cur_slot      = mem_addr[ADDR_W-1 -: SLOT_W];
    video_bank    = cfg.shadow ? VID_SHADOW : VID_NORMAL;
    mem_is_rom    = (cur_slot == '0);
    mem_bank      = slot_banks[cur_slot];
    mem_contended = !mem_is_rom && bank_contended(mem_bank);
  end
endmodule

// File: rtl/bank_pager.sv
module bank_pager
  import bank_pager_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              rom_sel,
  output logic [BANK_W-1:0] slot1_bank,
  output logic [BANK_W-1:0] slot2_bank,
  output logic [BANK_W-1:0] slot3_bank,
  output logic [BANK_W-1:0] video_bank,
  output logic              mem_is_rom,
  output logic [BANK_W-1:0] mem_bank,
  output logic              mem_contended
);
  logic              wr_hit;
  logic              wr_take;
  logic              locked;
  pg_cfg_t           cfg;
  logic [BANK_W-1:0] slot_banks [NSLOT];

  bank_pager_decode #(.ADDR_W(ADDR_W), .ZERO_A(1), .ZERO_B(ADDR_W-1)) u_dec (
    .io_wr(io_wr), .io_addr(io_addr), .hit(wr_hit)
  );

  bank_pager_reg u_reg (
    .clk(clk), .rst_n(rst_n), .hit(wr_hit), .data(io_data),
    .cfg(cfg), .take(wr_take)
  );

  bank_pager_map #(.ADDR_W(ADDR_W)) u_map (
    .cfg(cfg), .mem_addr(mem_addr), .slot_banks(slot_banks),
    .video_bank(video_bank), .mem_is_rom(mem_is_rom),
    .mem_bank(mem_bank), .mem_contended(mem_contended)
  );

  always_comb begin
    locked     = cfg.lock;
    rom_sel    = cfg.rom;
    slot1_bank = slot_banks[1];
    slot2_bank = slot_banks[2];
    slot3_bank = slot_banks[3];
  end
endmodule

// File: rtl/bank_pager_chk.sv
module bank_pager_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rom_sel,
  input logic [2:0]        slot3_bank,
  input logic [2:0]        video_bank,
  input logic              mem_contended,
  input logic              wr_take,
  input logic              locked
);
  logic dec_ok;
  always_comb dec_ok = io_wr && !io_addr[1] && !io_addr[ADDR_W-1];

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (slot3_bank == 3'd0 && !rom_sel && video_bank == 3'd5 && !locked));

  a_r2_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ok |=> ($stable(slot3_bank) && $stable(rom_sel) && $stable(video_bank)));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ok && !locked) |=> (slot3_bank == $past(io_data[2:0]) && rom_sel == $past(io_data[4])));

  a_r6_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ok && !locked && io_data[5]) |=> locked);

  a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(slot3_bank) && $stable(rom_sel) && $stable(video_bank) && locked));

  a_r6_no_take_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !wr_take);

  a_r8_rom_free: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[ADDR_W-1 -: 2] == 2'd0) |-> !mem_contended);

  a_r8_slot1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[ADDR_W-1 -: 2] == 2'd1) |-> mem_contended);
endmodule

bind bank_pager bank_pager_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_bank_pager.sv
module tb_bank_pager;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = 16'h7ffd;
  logic [7:0]  io_data = 0;
  logic [15:0] mem_addr = 0;
  logic        rom_sel, mem_is_rom, mem_contended;
  logic [2:0]  slot1_bank, slot2_bank, slot3_bank, video_bank, mem_bank;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model;  // last accepted byte, bench side
  bit         mlock;

  bank_pager dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bank(int slot, logic [7:0] d);
    if (slot == 1) return 5;
    if (slot == 2) return 2;
    if (slot == 3) return d & 7;
    return 0;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_addr = a; io_data = d;
    if (a[1] == 0 && a[15] == 0 && !mlock) begin
      model = d;
      mlock = d[5];
    end
    @(negedge clk);
    io_wr = 0;
    #2;
  endtask

  task automatic check_all(string req);
    chk({req, " rom"}, rom_sel, model[4]);
    chk({req, " top"}, slot3_bank, model & 7);
    chk({req, " vid"}, video_bank, model[3] ? 7 : 5);
    chk("R7 slot1", slot1_bank, 5);
    chk("R7 slot2", slot2_bank, 2);
    for (int s = 0; s < 4; s++) begin
      mem_addr = 16'(s * 16'h4000 + 16'h123);
      #1;
      chk("R8 is_rom", mem_is_rom, s == 0);
      chk("R8 bank", mem_bank, exp_bank(s, model));
      chk("R8 contended", mem_contended, (s != 0) && (exp_bank(s, model) % 2 == 1));
    end
  endtask

  task automatic do_reset();
    rst_n = 0; model = 0; mlock = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #2;
  endtask

  initial begin
    do_reset();
    check_all("R1");
    // R3 R4 R5 R9: sweep every byte with the lock bit clear
    for (int d = 0; d < 256; d++) begin
      if (d[5]) continue;
      wr(16'h7ffd, 8'(d));
      check_all("R3/R4/R5/R9");
    end
    // R2: decode sweep over bits 1 and 15 with assorted other bits
    for (int k = 0; k < 64; k++) begin
      logic [15:0] a = 16'(k * 16'h0a53) ^ 16'h5a5a;
      a[1] = k[0]; a[15] = k[1];
      wr(a, 8'(k * 7) & 8'hdf);
      check_all("R2");
    end
    // R6: locking write takes effect, then later writes are ignored
    wr(16'h7ffd, 8'h0a);
    wr(16'h7ffd, 8'h3b);
    check_all("R6 lock write");
    wr(16'h7ffd, 8'h04);
    check_all("R6 locked");
    wr(16'h0000, 8'h16);
    check_all("R6 locked");
    // R10: reset releases the lock
    do_reset();
    check_all("R1 R10 reset");
    wr(16'h7ffd, 8'h1e);
    check_all("R10 unlocked");
    chk("R10 top", slot3_bank, 6);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule